// File: doc/BRIEF.md
# Tamper Zeroization Sequencer

This controller runs the on-chip response to a tamper event on an SRAM-based programmable device whose bitstream key is a 256-bit volatile value kept alive by a battery. When a synchronized rising edge arrives on the tamper input, it first asks the key engine to wipe the stored key. After that request is acknowledged, it asks the key engine to load a replacement key. It then holds the device's active-low reconfiguration line low for a minimum time and waits for the device to release its active-low status line. Next it waits for configuration to complete. Finally it watches the error-detection logic until one full check cycle finishes, which shows that the reloaded configuration memory is intact.

Every key operation uses a request/acknowledge handshake guarded by a timeout. Key traffic is held back until a power-up hold-off has run out; an input picks a standard or a fast hold-off length. The result appears as a one-cycle success pulse or as a sticky failure flag. A second tamper edge that arrives while a response is already running does not restart it. It is recorded in a separate sticky flag instead.

Top module: `tamper_zeroize_seq`

## Requirements
- R1: The key-clear request rises first. The reprogram request rises only in the cycle after a cycle in which the clear request and its acknowledge were both high. `reconf_n_o` falls only in the cycle after a cycle in which the reprogram request and its acknowledge were both high.
- R2: Each sequence drives `reconf_n_o` low for exactly RST_CYC = ceil(RST_MIN_NS * CLK_HZ / 1e9) consecutive cycles. The default RST_MIN_NS is 500.
- R3: After `reconf_n_o` returns high, the block waits for `stat_n_i` to be high, then for `cfg_done_i` to be high. A cycle-complete pulse that arrives before both have been seen is ignored.
- R4: In the verify phase, a high `edc_cycle_i` with a low `edc_err_i` gives a `done_ok_o` pulse in the next cycle. A high `edc_err_i` sets `fail_o` instead, and it wins when both inputs are high in the same cycle.
- R5: No clear request is raised earlier than HOLD cycles after reset is released. HOLD = ceil(HOLD_FAST_US * CLK_HZ / 1e6) when `fast_por_i` = 1, and ceil(HOLD_STD_US * CLK_HZ / 1e6) otherwise. With a tamper edge already pending, the first request appears exactly HOLD cycles after reset.
- R6: A request stays high until it is acknowledged. If it has been high for ACK_TMO cycles with no acknowledge, it drops, `fail_o` is set, the block goes idle, and `reconf_n_o` is not pulsed.
- R7: `busy_o` is high from the cycle after acceptance until the sequence ends. `done_ok_o` lasts one cycle. `fail_o` stays high until the next sequence is accepted.
- R8: `tamper_i` passes through two synchronizer flops. A sequence is accepted on the third rising clock edge after `tamper_i` goes high, and a level held high starts only one sequence.
- R9: A tamper rising edge while `busy_o` is high does not restart the sequence. It sets `retamper_o`, which stays high until the next sequence is accepted.
- R10: `prog_key_o` equals `repl_key_i` while `prog_req_o` is high, and is all zeros at every other time. The key width is 256 bits.
- R11: During reset, `busy_o`, `done_ok_o`, `fail_o`, `retamper_o`, `clr_req_o` and `prog_req_o` are all low, and `reconf_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tamper_i | input | 1 | Asynchronous tamper detect |
| fast_por_i | input | 1 | 1 selects the fast power-up hold-off |
| repl_key_i | input | KEY_W | Replacement key |
| clr_req_o | output | 1 | Key wipe request |
| clr_ack_i | input | 1 | Key wipe acknowledge |
| prog_req_o | output | 1 | Key load request |
| prog_ack_i | input | 1 | Key load acknowledge |
| prog_key_o | output | KEY_W | Key offered with the load request, zero otherwise |
| reconf_n_o | output | 1 | Active-low reconfiguration drive |
| stat_n_i | input | 1 | Active-low device status, high when released |
| cfg_done_i | input | 1 | Configuration complete |
| edc_cycle_i | input | 1 | Error-detection cycle finished pulse |
| edc_err_i | input | 1 | Error-detection mismatch flag |
| busy_o | output | 1 | Sequence in progress |
| done_ok_o | output | 1 | One-cycle pulse on successful verification |
| fail_o | output | 1 | Sticky failure |
| retamper_o | output | 1 | Sticky tamper-while-busy |

## Verification
Two verify-phase events can fall in the same cycle: the error-detection mismatch flag and the cycle-finished pulse. The bench drives both in one cycle on purpose and expects `fail_o` high with no `done_ok_o` pulse. It also runs the flag alone and the pulse alone to confirm that each gives its own outcome. A cycle-finished pulse sent while the status line is still held low is then shown to have no effect on `done_ok_o`.

// File: rtl/tzs_pkg.sv
package tzs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PORWAIT,
      ST_CLR,
      ST_PROG,
      ST_RSTLO,
      ST_STAT,
      ST_CFG,
      ST_VERIFY
   } tzs_state_e;

   function automatic longint ceil_div(input longint num, input longint den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/tzs_edge_sync.sv
module tzs_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tzs_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], d_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tzs_tick_timer.sv
module tzs_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   output logic         expired_o
);
   if (W < 1) begin : g_bad_w
      $error("tzs_tick_timer: W must be positive");
   end

   logic [W-1:0] cnt_q;

   assign expired_o = ({1'b0, cnt_q} + (W+1)'(1)) >= {1'b0, limit_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cnt_q <= '0;
      else if (clr_i)      cnt_q <= '0;
      else if (!expired_o) cnt_q <= cnt_q + W'(1);
   end
endmodule

// File: rtl/tzs_edc_verify.sv
module tzs_edc_verify (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   input  logic cycle_i,
   input  logic err_i,
   output logic pass_o,
   output logic corrupt_o,
   output logic done_o
);
   assign corrupt_o = arm_i & err_i;
   assign pass_o    = arm_i & cycle_i & ~err_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) done_o <= 1'b0;
      else         done_o <= pass_o;
   end

   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R7
   AST_ERR_BLOCKS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arm_i && err_i) |=> !done_o); // R4
endmodule

// File: rtl/tamper_zeroize_seq.sv
module tamper_zeroize_seq
   import tzs_pkg::*;
#(
   parameter int CLK_HZ       = 50_000_000,
   parameter int HOLD_STD_US  = 200_000,
   parameter int HOLD_FAST_US = 9_000,
   parameter int RST_MIN_NS   = 500,
   parameter int ACK_TMO      = 1024,
   parameter int KEY_W        = 256,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tamper_i,
   input  logic             fast_por_i,
   input  logic [KEY_W-1:0] repl_key_i,
   output logic             clr_req_o,
   input  logic             clr_ack_i,
   output logic             prog_req_o,
   input  logic             prog_ack_i,
   output logic [KEY_W-1:0] prog_key_o,
   output logic             reconf_n_o,
   input  logic             stat_n_i,
   input  logic             cfg_done_i,
   input  logic             edc_cycle_i,
   input  logic             edc_err_i,
   output logic             busy_o,
   output logic             done_ok_o,
   output logic             fail_o,
   output logic             retamper_o
);
   localparam longint NS_PER_S = 64'd1_000_000_000;
   localparam longint US_PER_S = 64'd1_000_000;
   localparam int RST_CYC   = int'(ceil_div(longint'(RST_MIN_NS) * longint'(CLK_HZ), NS_PER_S));
   localparam int HOLD_STD  = int'(ceil_div(longint'(HOLD_STD_US) * longint'(CLK_HZ), US_PER_S));
   localparam int HOLD_FAST = int'(ceil_div(longint'(HOLD_FAST_US) * longint'(CLK_HZ), US_PER_S));
   localparam int MAX_A     = (HOLD_STD > HOLD_FAST) ? HOLD_STD : HOLD_FAST;
   localparam int MAX_B     = (RST_CYC > ACK_TMO) ? RST_CYC : ACK_TMO;
   localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W     = $clog2(MAX_CYC + 1);

   localparam logic [CNT_W-1:0] LIM_RST  = CNT_W'(RST_CYC);
   localparam logic [CNT_W-1:0] LIM_ACK  = CNT_W'(ACK_TMO);
   localparam logic [CNT_W-1:0] LIM_STD  = CNT_W'(HOLD_STD);
   localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(HOLD_FAST);

   if (CLK_HZ <= 0 || RST_MIN_NS <= 0 || HOLD_STD_US <= 0 || HOLD_FAST_US <= 0) begin : g_bad_time
      $error("tamper_zeroize_seq: timing parameters must be positive");
   end
   if (ACK_TMO < 2) begin : g_bad_tmo
      $error("tamper_zeroize_seq: ACK_TMO must be at least 2");
   end
   if (KEY_W != 256) begin : g_bad_key
      $error("tamper_zeroize_seq: key width must be 256");
   end

   tzs_state_e state_q, state_d;
   logic tamper_rise, por_ok, seq_exp, tmr_clr;
   logic start, fail_set, v_pass, v_corrupt;
   logic fail_q, retamper_q;
   logic [CNT_W-1:0] seq_limit, por_limit;

   tzs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (tamper_i),
      .rise_o (tamper_rise)
   );

   assign por_limit = fast_por_i ? LIM_FAST : LIM_STD;

   tzs_tick_timer #(.W(CNT_W)) u_por_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (1'b0),
      .limit_i   (por_limit),
      .expired_o (por_ok)
   );

   assign seq_limit = (state_q == ST_RSTLO) ? LIM_RST : LIM_ACK;
   assign tmr_clr   = (state_d != state_q);

   tzs_tick_timer #(.W(CNT_W)) u_seq_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (tmr_clr),
      .limit_i   (seq_limit),
      .expired_o (seq_exp)
   );

   tzs_edc_verify u_verify (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .arm_i     (state_q == ST_VERIFY),
      .cycle_i   (edc_cycle_i),
      .err_i     (edc_err_i),
      .pass_o    (v_pass),
      .corrupt_o (v_corrupt),
      .done_o    (done_ok_o)
   );

   assign start = (state_q == ST_IDLE) && tamper_rise;

   always_comb begin
      state_d  = state_q;
      fail_set = 1'b0;
      unique case (state_q)
         ST_IDLE:    if (tamper_rise) state_d = por_ok ? ST_CLR : ST_PORWAIT;
         ST_PORWAIT: if (por_ok) state_d = ST_CLR;
         ST_CLR: begin
            if (clr_ack_i) state_d = ST_PROG;
            else if (seq_exp) begin
               state_d  = ST_IDLE;
               fail_set = 1'b1;
            end
         end
         ST_PROG: begin
            if (prog_ack_i) state_d = ST_RSTLO;
            else if (seq_exp) begin
               state_d  = ST_IDLE;
               fail_set = 1'b1;
            end
         end
         ST_RSTLO:   if (seq_exp) state_d = ST_STAT;
         ST_STAT:    if (stat_n_i) state_d = ST_CFG;
         ST_CFG:     if (cfg_done_i) state_d = ST_VERIFY;
         ST_VERIFY: begin
            if (v_corrupt) begin
               state_d  = ST_IDLE;
               fail_set = 1'b1;
            end else if (v_pass) begin
               state_d  = ST_IDLE;
            end
         end
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= ST_IDLE;
         fail_q     <= 1'b0;
         retamper_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start)         fail_q <= 1'b0;
         else if (fail_set) fail_q <= 1'b1;
         if (start)                                      retamper_q <= 1'b0;
         else if (tamper_rise && state_q != ST_IDLE)     retamper_q <= 1'b1;
      end
   end

   assign clr_req_o  = (state_q == ST_CLR);
   assign prog_req_o = (state_q == ST_PROG);
   assign prog_key_o = prog_req_o ? repl_key_i : '0;
   assign reconf_n_o = (state_q != ST_RSTLO);
   assign busy_o     = (state_q != ST_IDLE);
   assign fail_o     = fail_q;
   assign retamper_o = retamper_q;

   // independent low-run counter for checking the reconfiguration pulse width
   logic [CNT_W-1:0] low_run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       low_run_q <= '0;
      else if (reconf_n_o)               low_run_q <= '0;
      else if (low_run_q != '1)          low_run_q <= low_run_q + CNT_W'(1);
   end

   AST_CLEAR_BEFORE_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(prog_req_o) |-> $past(clr_req_o && clr_ack_i)); // R1
   AST_PROG_BEFORE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(reconf_n_o) |-> $past(prog_req_o && prog_ack_i)); // R1
   AST_RESET_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(reconf_n_o) |-> (low_run_q >= LIM_RST)); // R2
   AST_HOLDOFF_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clr_req_o) |-> $past(por_ok)); // R5
   AST_ACK_TIMEOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_req_o && !clr_ack_i && seq_exp) |=> (!clr_req_o && fail_o)); // R6
   AST_CRC_FAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_VERIFY && edc_err_i) |=> (fail_o && !busy_o)); // R4
   AST_RETAMPER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && tamper_rise) |=> (retamper_o && busy_o)); // R9
endmodule

// File: tb/tamper_zeroize_seq_bench.sv
`timescale 1ns/1ps
module tamper_zeroize_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int P_CLK_HZ   = 13_000_000;
   localparam int P_STD_US   = 1500;
   localparam int P_FAST_US  = 70;
   localparam int P_RST_NS   = 500;
   localparam int P_TMO      = 12;
   localparam int KW         = 256;

   localparam longint RST_EXP  = (longint'(P_RST_NS) * P_CLK_HZ + 999_999_999) / 1_000_000_000;
   localparam longint FAST_EXP = (longint'(P_FAST_US) * P_CLK_HZ + 999_999) / 1_000_000;
   localparam longint STD_EXP  = (longint'(P_STD_US) * P_CLK_HZ + 999_999) / 1_000_000;

   logic clk = 0, rst_n = 0;
   logic tamper = 0, fast_por = 1, clr_ack = 0, prog_ack = 0;
   logic stat_n = 1, cfg_done = 0, edc_cycle = 0, edc_err = 0;
   logic [KW-1:0] repl_key = '0;
   logic clr_req, prog_req, reconf_n, busy, done_ok, fail, retamper;
   logic [KW-1:0] prog_key;

   int n_vec = 0, n_bad = 0;
   longint since_rst = 0;
   int low_run = 0, n_low_runs = 0;
   bit finished = 0;

   tamper_zeroize_seq #(
      .CLK_HZ(P_CLK_HZ), .HOLD_STD_US(P_STD_US), .HOLD_FAST_US(P_FAST_US),
      .RST_MIN_NS(P_RST_NS), .ACK_TMO(P_TMO), .KEY_W(KW), .SYNC_STAGES(2)
   ) u_tamper_zeroize_seq (
      .clk_i(clk), .rst_ni(rst_n), .tamper_i(tamper), .fast_por_i(fast_por),
      .repl_key_i(repl_key), .clr_req_o(clr_req), .clr_ack_i(clr_ack),
      .prog_req_o(prog_req), .prog_ack_i(prog_ack), .prog_key_o(prog_key),
      .reconf_n_o(reconf_n), .stat_n_i(stat_n), .cfg_done_i(cfg_done),
      .edc_cycle_i(edc_cycle), .edc_err_i(edc_err), .busy_o(busy),
      .done_ok_o(done_ok), .fail_o(fail), .retamper_o(retamper)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) since_rst <= 0;
      else        since_rst <= since_rst + 1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
      end
   endtask

   // R2 pulse width and R10 key gating, observed between edges
   always @(negedge clk) begin
      if (rst_n) begin
         if (!reconf_n) low_run++;
         else if (low_run != 0) begin
            chk(low_run == RST_EXP, "R2 reconf low width", low_run, RST_EXP);
            n_low_runs++;
            low_run = 0;
         end
         if (prog_req) chk(prog_key == repl_key, "R10 key offered", longint'(prog_key[63:0]), longint'(repl_key[63:0]));
         else          chk(prog_key == '0, "R10 key hidden", longint'(prog_key[63:0]), 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic fast);
      @(negedge clk);
      rst_n = 0; tamper = 0; clr_ack = 0; prog_ack = 0; stat_n = 1;
      cfg_done = 0; edc_cycle = 0; edc_err = 0; fast_por = fast;
      tick(3);
      chk(!busy && !done_ok && !fail && !retamper, "R11 flags in reset", {busy, done_ok, fail, retamper}, 0);
      chk(!clr_req && !prog_req && reconf_n, "R11 pins in reset", {clr_req, prog_req, reconf_n}, 1);
      rst_n = 1;
   endtask

   task automatic accept();
      tamper = 1;
      tick(2);
      chk(busy == 0, "R8 not before third edge", busy, 0);
      tick(1);
      chk(busy == 1, "R8 accepted on third edge", busy, 1);
      chk(!fail && !retamper, "R7 R9 flags cleared on start", {fail, retamper}, 0);
   endtask

   task automatic wait_clr(input longint por_exp);
      int guard = 0;
      while (!clr_req && guard < 30000) begin tick(1); guard++; end
      chk(clr_req, "R1 clear request raised", clr_req, 1);
      if (por_exp != 0) chk(since_rst == por_exp, "R5 hold-off length", since_rst, por_exp);
      chk(!prog_req && reconf_n, "R1 clear comes first", {prog_req, reconf_n}, 1);
   endtask

   // crcmode: 0 clean, 1 error alone, 2 error with cycle pulse
   task automatic run_seq(input int dclr, input int dprog, input int dstat, input int dcfg,
                          input int crcmode, input longint por_exp, input bit retamp);
      int guard;
      repl_key = {8{32'hC3A5_0000 + 32'(dclr * 16 + dprog)}};
      accept();
      wait_clr(por_exp);
      if (retamp) begin
         tamper = 0; tick(2); tamper = 1; tick(4);
         chk(retamper == 1, "R9 retamper flagged", retamper, 1);
         chk(busy && clr_req, "R9 no restart", {busy, clr_req}, 3);
      end
      for (int i = 0; i < dclr; i++) begin
         tick(1);
         chk(clr_req && !prog_req, "R6 request held until ack", {clr_req, prog_req}, 2);
      end
      clr_ack = 1; tick(1); clr_ack = 0;
      chk(!clr_req && prog_req, "R1 reprogram after clear ack", {clr_req, prog_req}, 1);
      for (int i = 0; i < dprog; i++) begin
         tick(1);
         chk(reconf_n == 1, "R1 no reset before reprogram ack", reconf_n, 1);
      end
      prog_ack = 1; tick(1); prog_ack = 0;
      chk(!prog_req && !reconf_n, "R1 reset after reprogram ack", {prog_req, reconf_n}, 0);
      stat_n = 0; cfg_done = 0;
      guard = 0;
      while (!reconf_n && guard < 100) begin tick(1); guard++; end
      edc_cycle = 1; tick(1); edc_cycle = 0;
      tick(dstat);
      chk(busy && !done_ok, "R3 waits for status release", {busy, done_ok}, 2);
      stat_n = 1; tick(1);
      tick(dcfg);
      chk(busy && !done_ok, "R3 waits for config done", {busy, done_ok}, 2);
      cfg_done = 1; tick(1);
      tick(2);
      chk(!done_ok && busy, "R4 no verdict without cycle pulse", {busy, done_ok}, 2);
      case (crcmode)
         0: begin
            edc_cycle = 1; tick(1); edc_cycle = 0;
            chk(done_ok && !busy && !fail, "R4 verified pulse", {done_ok, busy, fail}, 4);
            tick(1);
            chk(!done_ok, "R7 done is one cycle", done_ok, 0);
         end
         1: begin
            edc_err = 1; tick(1); edc_err = 0;
            chk(fail && !busy && !done_ok, "R4 crc error fails", {fail, busy, done_ok}, 4);
         end
         default: begin
            edc_err = 1; edc_cycle = 1; tick(1); edc_err = 0; edc_cycle = 0;
            chk(fail && !done_ok, "R4 error wins same cycle", {fail, done_ok}, 2);
            tick(1);
            chk(!done_ok, "R4 no late pulse", done_ok, 0);
         end
      endcase
      cfg_done = 0;
      tick(3);
      chk(fail == (crcmode != 0), "R7 fail sticky", fail, crcmode != 0);
      chk(retamper == retamp, "R9 retamper sticky", retamper, retamp);
      chk(!busy, "R8 held level no second start", busy, 0);
      tamper = 0;
      tick(3);
   endtask

   task automatic run_tmo(input bit on_prog);
      int n = 0, runs0;
      runs0 = n_low_runs;
      accept();
      wait_clr(0);
      if (on_prog) begin
         clr_ack = 1; tick(1); clr_ack = 0;
         while (prog_req && n < 100) begin n++; tick(1); end
      end else begin
         while (clr_req && n < 100) begin n++; tick(1); end
      end
      chk(n == P_TMO, "R6 request length before timeout", n, P_TMO);
      chk(fail && !busy && !prog_req && !clr_req, "R6 timeout fails", {fail, busy, prog_req, clr_req}, 8);
      tick(RST_EXP + 4);
      chk(n_low_runs == runs0, "R6 no reset pulse after timeout", n_low_runs, runs0);
      chk(fail, "R7 fail sticky while idle", fail, 1);
      tamper = 0;
      tick(3);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      do_reset(1'b1);
      run_seq(0, 0, 0, 0, 0, FAST_EXP, 1'b0);
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            run_seq(a, b, (a + b) % 3, b % 2, 0, 0, 1'b0);
      run_seq(1, 2, 1, 1, 1, 0, 1'b0);
      run_seq(2, 0, 0, 2, 2, 0, 1'b0);
      run_seq(0, 1, 2, 0, 0, 0, 1'b1);
      run_seq(1, 1, 1, 1, 0, 0, 1'b0);
      run_tmo(1'b0);
      run_tmo(1'b1);
      run_seq(3, 3, 0, 0, 0, 0, 1'b0);
      do_reset(1'b0);
      run_seq(1, 1, 1, 1, 0, STD_EXP, 1'b0);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule